// File: doc/BRIEF.md
# Multiplexed-Bus Memory Target

This block is a synchronous 32-bit target on a shared parallel bus that carries address and data on the same lines. It watches for an initiator to pull the cycle-start strobe low. It then captures the address and the four-bit command, and decides whether the access belongs to it: a memory read or a memory write that falls inside an aligned address window. A claimed access is acknowledged with the device-select strobe. The block then moves single words or bursts between the bus and a small local word store. All strobes are active low, and every driven pin has its own output-enable signal, so no tri-state logic sits inside the block.

The data phases follow a valid/ready rule. The initiator's ready strobe low means its word is valid: write data is on the bus, or it will accept read data. The target's ready strobe low means the target accepts or supplies the word. A word moves on a clock edge only when both strobes are low in that cycle. Either side applies back-pressure by holding its strobe high, and the word on offer is then held until the edge where both are low. The local `stall_req` input is the target's back-pressure: while it is high, the target's ready strobe stays high. Reads insert one turnaround cycle before the target drives the data lines. At the end of an access the block drives its strobes high for one cycle and then releases them.

Top module: `bus_tgt`

## Requirements
- R1: After reset, `devsel_n` and `trdy_n` are high, `ctl_oe` and `ad_oe` are low, and every word of the local store reads as zero.
- R2: Only command 4'b0110 (memory read) and command 4'b0111 (memory write) with an address in [BASE_ADDR, BASE_ADDR + 4*DEPTH) are claimed. For any other access, `devsel_n` stays high and `ctl_oe` and `ad_oe` stay low for the whole access, and the store is left unchanged.
- R3: For a claimed access, `devsel_n` is low in the cycle that follows the address phase (the cycle in which `frame_n` was first sampled low).
- R4: For a claimed read, the cycle after the address phase is a turnaround cycle in which `ad_oe` is low and `trdy_n` is high. From the next cycle, `ad_out` carries the addressed word.
- R5: A word transfers only on an edge where `irdy_n` and `trdy_n` are both low. While `stall_req` is high, `trdy_n` is high. No word is lost or repeated, whatever mix of initiator and target wait cycles occurs.
- R6: The first word index is address bits [5:2] (for DEPTH=16). The index advances by one after each transfer and wraps from DEPTH-1 to 0.
- R7: A write transfer updates only the byte lanes whose `cbe_n` bit is low, where bit n covers `ad_in[8n+7:8n]`.
- R8: A transfer made with `frame_n` high is the last one of the access, and the block then returns to idle, ready to claim the next access.
- R9: After the last transfer, `devsel_n` and `trdy_n` are driven high with `ctl_oe` still high for exactly one cycle. `ctl_oe` is then low, unless a new access has already been claimed.
- R10: `ad_oe` is high only in the data phases of a claimed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Access-in-progress strobe from the initiator, active low |
| irdy_n | input | 1 | Initiator ready strobe, active low |
| cbe_n | input | 4 | Command during the address phase, active-low byte enables during data phases |
| ad_in | input | 32 | Multiplexed address/data lines as seen by the target |
| stall_req | input | 1 | Local back-pressure: holds the target ready strobe high |
| ad_out | output | 32 | Read data to be placed on the address/data lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| trdy_n | output | 1 | Target ready strobe, active low |
| devsel_n | output | 1 | Device-select acknowledge, active low |
| ctl_oe | output | 1 | Output enable for `trdy_n` and `devsel_n` |

## Verification
The bound checker watches the relations between the strobes on every cycle. The target ready strobe is never low without device select, and never low while the block stalls. Device select falls only one cycle after the cycle-start strobe was low, and never while read data is being driven. Its release is preceded by a final handshake and followed by a single driven-high cycle. The bench scenarios cover the data itself: byte-lane merging, burst index wrap, words moved under mixed wait cycles, and accesses that must be ignored. For those, a scoreboard replays reads against a model of the store.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for an address phase
    ST_TURN = 2'd1,  // read turnaround after the address phase
    ST_DATA = 2'd2,  // data phases, more may follow
    ST_LAST = 2'd3   // initiator flagged the final phase, not yet done
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/bt_decode.sv
module bt_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
  parameter int          DEPTH     = 16,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic [31:0]      ad_in,
  input  logic [3:0]       cbe_n,
  output logic             hit,
  output logic             is_wr,
  output logic [IDX_W-1:0] idx
);
  import bt_pkg::*;

  localparam logic [32:0] WIN_END = {1'b0, BASE_ADDR} + 33'(DEPTH * 4);

  logic cmd_ok;
  logic in_win;

  always_comb begin
    cmd_ok = (cbe_n == CMD_MEM_RD) || (cbe_n == CMD_MEM_WR);
    in_win = (ad_in >= BASE_ADDR) && ({1'b0, ad_in} < WIN_END);
    hit    = cmd_ok && in_win;
    is_wr  = (cbe_n == CMD_MEM_WR);
    // window is aligned to its own size, so low address bits index the store
    idx    = ad_in[2 +: IDX_W];
  end
endmodule

// File: rtl/bt_store.sv
module bt_store #(
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       be_n,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (we && !be_n[g]) begin
        lane_mem[widx] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = lane_mem[ridx];
  end
endmodule

// File: rtl/bt_fsm.sv
module bt_fsm #(
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             stall_req,
  input  logic             hit,
  input  logic             is_wr,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_en,
  output logic             ad_oe,
  output logic             trdy_n,
  output logic             devsel_n,
  output logic             ctl_oe
);
  import bt_pkg::*;

  tgt_state_e       state_q, state_d;
  logic             wr_q;
  logic             rel_q;
  logic             foreign_q;
  logic [IDX_W-1:0] idx_q;
  logic             data_ph;
  logic             xfer;
  logic             final_xfer;
  logic             claim;

  always_comb begin
    data_ph    = (state_q == ST_DATA) || (state_q == ST_LAST);
    xfer       = data_ph && !irdy_n && !stall_req;
    final_xfer = xfer && frame_n;
    claim      = (state_q == ST_IDLE) && !frame_n && !foreign_q && hit;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (claim) state_d = is_wr ? ST_DATA : ST_TURN;
      ST_TURN: state_d = ST_DATA;
      ST_DATA: begin
        if (final_xfer)   state_d = ST_IDLE;
        else if (frame_n) state_d = ST_LAST;
      end
      ST_LAST: if (xfer) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      rel_q     <= 1'b0;
      foreign_q <= 1'b0;
      idx_q     <= '0;
    end else begin
      state_q <= state_d;
      rel_q   <= final_xfer;
      if (claim) begin
        wr_q  <= is_wr;
        idx_q <= idx_in;
      end else if (xfer) begin
        idx_q <= idx_q + 1'b1;  // DEPTH is a power of two: wraps naturally
      end
      if (state_q == ST_IDLE && !frame_n && !foreign_q && !hit)
        foreign_q <= 1'b1;
      else if (foreign_q && frame_n && irdy_n)
        foreign_q <= 1'b0;
    end
  end

  always_comb begin
    cur_idx  = idx_q;
    wr_en    = xfer && wr_q;
    ad_oe    = data_ph && !wr_q;
    trdy_n   = !(data_ph && !stall_req);
    devsel_n = (state_q == ST_IDLE);
    ctl_oe   = (state_q != ST_IDLE) || rel_q;
  end
endmodule

// File: rtl/bus_tgt.sv
module bus_tgt #(
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
  parameter int          DEPTH     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  input  logic        stall_req,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        trdy_n,
  output logic        devsel_n,
  output logic        ctl_oe
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             hit;
  logic             is_wr;
  logic [IDX_W-1:0] dec_idx;
  logic [IDX_W-1:0] cur_idx;
  logic             wr_en;

  bt_decode #(.BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH)) u_decode (
    .ad_in (ad_in),
    .cbe_n (cbe_n),
    .hit   (hit),
    .is_wr (is_wr),
    .idx   (dec_idx)
  );

  bt_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .stall_req (stall_req),
    .hit       (hit),
    .is_wr     (is_wr),
    .idx_in    (dec_idx),
    .cur_idx   (cur_idx),
    .wr_en     (wr_en),
    .ad_oe     (ad_oe),
    .trdy_n    (trdy_n),
    .devsel_n  (devsel_n),
    .ctl_oe    (ctl_oe)
  );

  bt_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .be_n  (cbe_n),
    .widx  (cur_idx),
    .wdata (ad_in),
    .ridx  (cur_idx),
    .rdata (ad_out)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic [3:0]  cbe_n,
  input logic [31:0] ad_in,
  input logic        stall_req,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        trdy_n,
  input logic        devsel_n,
  input logic        ctl_oe
);
  AST_RELEASED_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> (devsel_n && trdy_n)); // R1

  AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n); // R5

  AST_STALL_HOLDS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> trdy_n); // R5

  AST_DEVSEL_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n)); // R3

  AST_TURNAROUND_NO_AD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> (!ad_oe && trdy_n || !ad_oe)); // R4

  AST_AD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!devsel_n && ctl_oe)); // R10

  AST_END_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |-> $past(frame_n && !irdy_n && !trdy_n)); // R8

  AST_RELEASE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |-> (ctl_oe && trdy_n && !ad_oe)); // R9

  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |=> (!ctl_oe || !devsel_n)); // R9

  wire unused_ok = ^{cbe_n, ad_in, ad_out};
endmodule

bind bus_tgt bt_checker u_chk (.*);

// File: tb/bus_tgt_bench.sv
module bus_tgt_bench;
  localparam logic [31:0] TB_BASE = 32'h0001_0000;
  localparam int          TB_DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic        stall_req = 1'b0;
  logic [31:0] ad_out;
  logic        ad_oe, trdy_n, devsel_n, ctl_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] model [TB_DEPTH];
  logic [31:0] exp_q [$];

  always #5 clk = ~clk;

  bus_tgt #(.BASE_ADDR(TB_BASE), .DEPTH(TB_DEPTH)) u_bus_tgt (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .stall_req(stall_req), .ad_out(ad_out),
    .ad_oe(ad_oe), .trdy_n(trdy_n), .devsel_n(devsel_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: every read word handed over is popped and compared (R5, R6)
  always @(negedge clk) begin
    if (rst_n && !irdy_n && !trdy_n && ad_oe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "read word with nothing expected", ad_out, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(ad_out === e, "R6", "read data", ad_out, e);
      end
    end
  end

  // one claimed access of n words; stall/iwait every k cycles (0 = never)
  task automatic burst(input bit wr, input logic [31:0] addr, input int n,
                       input logic [3:0] be, input int stall_every,
                       input int iw_every, input logic [31:0] seed);
    int idx0, k, cyc;
    bit done, oe_bad;
    idx0 = int'((addr - TB_BASE) >> 2) % TB_DEPTH;
    if (!wr)
      for (int j = 0; j < n; j++) exp_q.push_back(model[(idx0 + j) % TB_DEPTH]);
    @(posedge clk); #1;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = wr ? 4'b0111 : 4'b0110;
    stall_req = 1'b0;
    @(posedge clk); #1;
    k = 0; cyc = 0; oe_bad = 1'b0;
    while (k < n && cyc < 400) begin
      irdy_n = (iw_every != 0 && cyc % iw_every == 1);
      if (k == n - 1 && !irdy_n) frame_n = 1'b1;
      stall_req = (stall_every != 0 && cyc % stall_every == 0);
      ad_in = wr ? seed + 32'(k) * 32'h0101_0101 : 32'h0;
      cbe_n = be;
      @(negedge clk);
      if (cyc == 0) begin
        chk(devsel_n == 1'b0, "R3", "devsel after address phase", 32'(devsel_n), 32'h0);
        if (!wr) chk(!ad_oe && trdy_n, "R4", "turnaround oe/trdy",
                     {30'h0, ad_oe, trdy_n}, 32'h1);
      end
      if (wr && ad_oe) oe_bad = 1'b1;
      if (stall_req && !trdy_n) oe_bad = 1'b1;
      done = !irdy_n && !trdy_n;
      @(posedge clk); #1;
      if (done) begin
        if (wr)
          for (int b = 0; b < 4; b++)
            if (!be[b]) model[(idx0 + k) % TB_DEPTH][8*b +: 8] = ad_in[8*b +: 8];
        k++;
      end
      cyc++;
    end
    chk(k == n, "R5", "words completed", 32'(k), 32'(n));
    chk(!oe_bad, "R10", "no AD drive on write / trdy low while stalled", 32'(oe_bad), 32'h0);
    frame_n = 1'b1; irdy_n = 1'b1; stall_req = 1'b0; cbe_n = 4'hF; ad_in = '0;
    @(negedge clk);
    chk(ctl_oe && devsel_n && trdy_n && !ad_oe, "R9", "driven-high release cycle",
        {28'h0, ctl_oe, devsel_n, trdy_n, ad_oe}, 32'hE);
    @(posedge clk); #1;
    @(negedge clk);
    chk(!ctl_oe, "R8", "back to idle, strobes released", 32'(ctl_oe), 32'h0);
    chk(exp_q.size() == 0, "R5", "no read word left over", 32'(exp_q.size()), 32'h0);
  endtask

  // access that must not be claimed (R2)
  task automatic foreign(input logic [3:0] cmd, input logic [31:0] addr);
    bit bad;
    bad = 1'b0;
    @(posedge clk); #1;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(posedge clk); #1;
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hDEAD_BEEF; cbe_n = 4'h0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (!devsel_n || ctl_oe || ad_oe) bad = 1'b1;
      @(posedge clk); #1;
      irdy_n = 1'b1;
    end
    chk(!bad, "R2", "unclaimed access left bus untouched", 32'(bad), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < TB_DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && !ctl_oe && !ad_oe, "R1", "reset outputs",
        {28'h0, devsel_n, trdy_n, ctl_oe, ad_oe}, 32'hC);
    // R1: store reads zero after reset
    burst(1'b0, TB_BASE + 32'h8, 3, 4'h0, 0, 0, 0);
    // R7 R8: full-word write burst over the whole store
    burst(1'b1, TB_BASE, 16, 4'h0, 0, 0, 32'h1000_0001);
    // R6: read it all back
    burst(1'b0, TB_BASE, 16, 4'h0, 0, 0, 0);
    // R7 R5: partial lanes (bits 0 and 2 low -> lanes 0,2 written) with waits both sides
    burst(1'b1, TB_BASE + 32'h14, 3, 4'b1010, 3, 4, 32'hA0B0_C0D0);
    // R6 R5: wrapping read from word 14 with target stalls
    burst(1'b0, TB_BASE + 32'h38, 5, 4'h0, 2, 0, 0);
    // R7: single write with upper lanes only, then single read (R8)
    burst(1'b1, TB_BASE + 32'h3C, 1, 4'b0011, 0, 0, 32'h5566_7788);
    burst(1'b0, TB_BASE + 32'h3C, 1, 4'h0, 0, 3, 0);
    // R2: out of window, and a non-memory command inside the window
    foreign(4'b0111, TB_BASE + 32'h40);
    foreign(4'b0011, TB_BASE);
    foreign(4'b0111, TB_BASE - 32'h4);
    // R2: store unchanged, and a claim still works afterwards
    burst(1'b0, TB_BASE, 16, 4'h0, 5, 2, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule